// File: doc/BRIEF.md
# Signalling Channel Byte Accumulator

This block sits between a TDM timeslot interface and a processor port and handles the narrow signalling channel carried in one timeslot of every frame. Once per frame the timeslot side presents a strobe together with the received signalling bits. The block shifts those bits into a receive shifter and, in the same event, delivers the next transmit bits from a transmit shifter. Two bits are moved per frame at the default rate. One bit is moved per frame when the low-rate option is selected.

When a full byte has been gathered, the block copies it into a read-holding register and raises an interrupt. The processor reads the byte, which clears the interrupt, and writes the next byte to send. That written byte goes into the transmit shifter at the next byte boundary. Because the frame clock runs asynchronously to the processor, the interrupt tells the processor when the exchange window is open.

An enable input controls the drive of the transmit slot and of the interrupt pin. Those outputs are modelled as data plus an output-enable, and the output-enables are low while the block is disabled. Reception continues whether or not the block is enabled.

Top module: `dch_accum`

## Requirements
- R1: After reset, `irq` is 0, `rd_data` is 8'h00 and `tx_bits` is 2'b11. With `cfg_enable` low, both `tx_oe` and `irq_oe` are 0.
- R2: In two-bit mode (`cfg_rate_low`=0), each `frame_stb` shifts `rx_bits` in. Bit 1 of `rx_bits` is the earlier bit. After four frames, `rd_data` holds the pair from the first frame in bits 7:6, the second in 5:4, the third in 3:2 and the fourth in 1:0.
- R3: `irq` rises in the cycle after the frame that completes a byte, and it does not rise after any earlier frame of that byte.
- R4: In one-bit mode (`cfg_rate_low`=1), only `rx_bits[1]` is taken on each frame, and `rx_bits[0]` has no effect. A byte completes after eight frames, with the oldest bit in bit 7.
- R5: A one-cycle `rd_stb` clears `irq` in the next cycle and leaves `rd_data` unchanged.
- R6: In two-bit mode, a byte written through `wr_stb`/`wr_data` is sent during the byte period after the next byte boundary. It goes out most significant pair first, with one pair on `tx_bits` per frame.
- R7: In one-bit mode, the written byte goes out one bit per frame on `tx_bits[1]`, most significant bit first, while `tx_bits[0]` stays 1.
- R8: With `cfg_enable` low, `tx_oe` and `irq_oe` are 0, but received bits still accumulate and still update `rd_data` at each byte boundary.
- R9: Before any byte has been written, the transmit slot sends all ones.
- R10: `rd_data` holds its value between byte boundaries.
- R11: If a byte completes in the same cycle as `rd_stb`, `irq` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables drive of transmit slot and interrupt |
| cfg_rate_low | input | 1 | 1: one bit per frame, 0: two bits per frame |
| frame_stb | input | 1 | One-cycle pulse for the signalling timeslot of a frame |
| rx_bits | input | 2 | Received bits for this frame, bit 1 earlier |
| tx_bits | output | 2 | Bits transmitted in the latest frame, bit 1 earlier |
| tx_oe | output | 1 | Drive enable for the transmit slot |
| rd_stb | input | 1 | Processor read of the data register |
| rd_data | output | 8 | Last completed received byte |
| wr_stb | input | 1 | Processor write of the data register |
| wr_data | input | 8 | Byte to transmit |
| irq | output | 1 | Byte-exchange interrupt level |
| irq_oe | output | 1 | Drive enable for the interrupt pin |

## Verification
The hardest case to reach from the ports is a byte boundary that lands in the same cycle as a processor read. There, setting and clearing the interrupt compete, and only a read strobe placed exactly on the completing frame strobe can show which one wins. The bench resets before each scenario, so it knows the frame count at every point. It can therefore drive `rd_stb` alongside the fourth frame strobe. Transmit timing is checked the same way. The bench writes a byte early in one byte period and then follows `tx_bits` frame by frame across the idle period and the period after it.

// File: rtl/dch_pkg.sv
package dch_pkg;

    localparam int DCH_BYTE_W = 8;
    localparam int DCH_SLOT_W = 2;

    typedef enum logic {
        RATE_TWO_BIT = 1'b0,
        RATE_ONE_BIT = 1'b1
    } dch_rate_e;

    typedef struct packed {
        logic                  stb;
        logic [DCH_SLOT_W-1:0] bits;
    } dch_slot_t;

    function automatic int frames_per_byte(input dch_rate_e rate, input int byte_w);
        return (rate == RATE_ONE_BIT) ? byte_w : byte_w / DCH_SLOT_W;
    endfunction

endpackage

// File: rtl/dch_frame_counter.sv
module dch_frame_counter
    import dch_pkg::*;
#(
    parameter int BYTE_W = DCH_BYTE_W,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  dch_rate_e        rate,
    output logic             byte_done,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        limit     = CNT_W'(frames_per_byte(rate, BYTE_W));
        next_cnt  = cnt + CNT_W'(1);
        byte_done = stb && (next_cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= byte_done ? '0 : next_cnt;
        end
    end
endmodule

// File: rtl/dch_rx_accum.sv
module dch_rx_accum
    import dch_pkg::*;
#(
    parameter int BYTE_W = DCH_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  dch_slot_t         slot,
    input  dch_rate_e         rate,
    input  logic              byte_done,
    output logic [BYTE_W-1:0] hold
);
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nxt;

    always_comb begin
        if (rate == RATE_ONE_BIT) begin
            shreg_nxt = {shreg[BYTE_W-2:0], slot.bits[1]};
        end else begin
            shreg_nxt = {shreg[BYTE_W-3:0], slot.bits};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            hold  <= '0;
        end else if (slot.stb) begin
            shreg <= shreg_nxt;
            if (byte_done) begin
                hold <= shreg_nxt;
            end
        end
    end
endmodule

// File: rtl/dch_tx_serial.sv
module dch_tx_serial
    import dch_pkg::*;
#(
    parameter int BYTE_W = DCH_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stb,
    input  dch_rate_e             rate,
    input  logic                  byte_done,
    input  logic                  wr_stb,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [DCH_SLOT_W-1:0] bits_q
);
    logic [BYTE_W-1:0] wr_hold;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nxt;
    logic [DCH_SLOT_W-1:0] out_nxt;

    always_comb begin
        if (rate == RATE_ONE_BIT) begin
            out_nxt   = {shreg[BYTE_W-1], 1'b1};
            shreg_nxt = {shreg[BYTE_W-2:0], 1'b1};
        end else begin
            out_nxt   = shreg[BYTE_W-1:BYTE_W-2];
            shreg_nxt = {shreg[BYTE_W-3:0], 2'b11};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hold <= '1;
            shreg   <= '1;
            bits_q  <= '1;
        end else begin
            if (wr_stb) begin
                wr_hold <= wr_data;
            end
            if (stb) begin
                bits_q <= out_nxt;
                shreg  <= byte_done ? wr_hold : shreg_nxt;
            end
        end
    end
endmodule

// File: rtl/dch_accum.sv
module dch_accum
    import dch_pkg::*;
#(
    parameter int BYTE_W = DCH_BYTE_W,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_rate_low,
    input  logic              frame_stb,
    input  logic [1:0]        rx_bits,
    output logic [1:0]        tx_bits,
    output logic              tx_oe,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              irq,
    output logic              irq_oe
);
    dch_rate_e        rate;
    dch_slot_t        slot;
    logic             byte_done;
    logic [CNT_W-1:0] frame_cnt;

    always_comb begin
        rate      = cfg_rate_low ? RATE_ONE_BIT : RATE_TWO_BIT;
        slot.stb  = frame_stb;
        slot.bits = rx_bits;
        tx_oe     = cfg_enable;
        irq_oe    = cfg_enable;
    end

    dch_frame_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk(clk), .rst(rst), .stb(frame_stb), .rate(rate),
        .byte_done(byte_done), .cnt(frame_cnt)
    );

    dch_rx_accum #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst(rst), .slot(slot), .rate(rate),
        .byte_done(byte_done), .hold(rd_data)
    );

    dch_tx_serial #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst(rst), .stb(frame_stb), .rate(rate),
        .byte_done(byte_done), .wr_stb(wr_stb), .wr_data(wr_data),
        .bits_q(tx_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (byte_done) begin
            irq <= 1'b1;
        end else if (rd_stb) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/dch_accum_chk.sv
module dch_accum_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_enable,
    input logic              rd_stb,
    input logic              byte_done,
    input logic [CNT_W-1:0]  frame_cnt,
    input logic [BYTE_W-1:0] rd_data,
    input logic              irq,
    input logic              tx_oe,
    input logic              irq_oe
);
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> irq); // R11

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(byte_done)); // R3

    AST_IRQ_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !byte_done) |=> !irq); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> $stable(rd_data)); // R10

    AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |-> (!tx_oe && !irq_oe)); // R8

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        frame_cnt < CNT_W'(BYTE_W)); // R4
endmodule

bind dch_accum dch_accum_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .rd_stb(rd_stb),
    .byte_done(byte_done), .frame_cnt(frame_cnt), .rd_data(rd_data),
    .irq(irq), .tx_oe(tx_oe), .irq_oe(irq_oe)
);

// File: tb/dch_accum_tb.sv
module dch_accum_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_enable, cfg_rate_low, frame_stb, rd_stb, wr_stb;
    logic [1:0] rx_bits, tx_bits;
    logic [7:0] rd_data, wr_data;
    logic       tx_oe, irq, irq_oe;
    int         n_run = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    dch_accum u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_rate_low(cfg_rate_low),
        .frame_stb(frame_stb), .rx_bits(rx_bits), .tx_bits(tx_bits), .tx_oe(tx_oe),
        .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data),
        .irq(irq), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en, input logic low);
        @(negedge clk);
        rst = 1'b1; cfg_enable = en; cfg_rate_low = low; frame_stb = 1'b0;
        rx_bits = 2'b00; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] rx, input logic rd);
        frame_stb = 1'b1; rx_bits = rx; rd_stb = rd;
        @(negedge clk);
        frame_stb = 1'b0; rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b0);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 tx_bits", {6'd0, tx_bits}, 8'h03);
        check("R1 oe", {6'd0, tx_oe, irq_oe}, 8'h00);
    endtask

    task automatic t_rx_two;
        do_reset(1'b1, 1'b0);
        frame(2'b10, 1'b0); frame(2'b01, 1'b0); frame(2'b11, 1'b0);
        check("R3 no early irq", {7'd0, irq}, 8'h00);
        frame(2'b00, 1'b0);
        check("R3 irq after 4th", {7'd0, irq}, 8'h01);
        check("R2 byte order", rd_data, 8'h9C);
        check("R8 oe on", {6'd0, tx_oe, irq_oe}, 8'h03);
        frame(2'b11, 1'b0); frame(2'b11, 1'b0);
        check("R10 hold", rd_data, 8'h9C);
        frame(2'b01, 1'b0); frame(2'b10, 1'b0);
        check("R2 second byte", rd_data, 8'hF6);
    endtask

    task automatic t_rx_one;
        logic [7:0] pat = 8'hB2;
        do_reset(1'b1, 1'b1);
        for (int i = 7; i >= 1; i--) frame({pat[i], 1'b1}, 1'b0);
        check("R4 no irq at 7", {7'd0, irq}, 8'h00);
        frame({pat[0], 1'b1}, 1'b0);
        check("R4 irq at 8", {7'd0, irq}, 8'h01);
        check("R4 byte", rd_data, 8'hB2);
    endtask

    task automatic t_irq_clear;
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) frame(2'b01, 1'b0);
        check("R5 set", {7'd0, irq}, 8'h01);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R5 cleared", {7'd0, irq}, 8'h00);
        check("R5 data kept", rd_data, 8'h55);
    endtask

    task automatic t_set_wins;
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) frame(2'b11, 1'b0);
        frame(2'b10, 1'b1);
        check("R11 set wins", {7'd0, irq}, 8'h01);
        check("R11 data", rd_data, 8'hFE);
    endtask

    task automatic t_tx_two;
        logic [7:0] w = 8'hA5;
        do_reset(1'b1, 1'b0);
        write_byte(w);
        for (int i = 0; i < 4; i++) begin
            frame(2'b00, 1'b0);
            check("R9 idle ones", {6'd0, tx_bits}, 8'h03);
        end
        for (int i = 3; i >= 0; i--) begin
            frame(2'b00, 1'b0);
            check("R6 pair", {6'd0, tx_bits}, {6'd0, w[2*i+1], w[2*i]});
        end
    endtask

    task automatic t_tx_one;
        logic [7:0] w = 8'h96;
        do_reset(1'b1, 1'b1);
        write_byte(w);
        for (int i = 0; i < 8; i++) frame(2'b00, 1'b0);
        check("R9 idle ones low rate", {6'd0, tx_bits}, 8'h03);
        for (int i = 7; i >= 0; i--) begin
            frame(2'b00, 1'b0);
            check("R7 bit", {6'd0, tx_bits}, {6'd0, w[i], 1'b1});
        end
    endtask

    task automatic t_disable;
        do_reset(1'b0, 1'b0);
        check("R8 oe off", {6'd0, tx_oe, irq_oe}, 8'h00);
        frame(2'b00, 1'b0); frame(2'b11, 1'b0); frame(2'b00, 1'b0); frame(2'b11, 1'b0);
        check("R8 rx still runs", rd_data, 8'h33);
        check("R8 oe still off", {6'd0, tx_oe, irq_oe}, 8'h00);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        t_reset();
        t_rx_two();
        t_rx_one();
        t_irq_clear();
        t_set_wins();
        t_tx_two();
        t_tx_one();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule